// File: doc/BRIEF.md
# Spike Mesh Router Node

One router node of a two-dimensional mesh of neuromorphic cores. The node has five ports: one to its local core and one to each planar neighbour (north, south, east, west). Each port has a valid/ready stream in and a valid/ready stream out. Packets are trains of flits. Two sideband bits mark the head flit and the tail flit. The head flit carries a message class, a chip number and the destination core coordinates. The node routes X first and then Y. A packet bound for another chip goes west toward the column-0 edge, where the chip link sits.

Spike packets name a destination column and a span of rows. Once a spike reaches that column, every node inside the span keeps a copy for its core. It also passes the packet on toward the span ends it has not yet covered. A copy is never sent back out the port it arrived on. A flit that forks leaves its input buffer only after every requested output has taken it.

Each output gives priority in rotation among the inputs that want it. A packet keeps the output until its tail flit has gone. A counter tracks the spike packets held in the input buffers. The `idle_o` output is high while that counter is zero, and the barrier logic outside the node uses it to detect that no spikes are in flight.

Top module: `spike_router`

## Requirements
- R1: Head data bits [39:37] hold the class: 0 write, 1 read request, 2 read response, 3 spike, 4 barrier. Bits [36:23] hold the 14-bit chip number. Bits [22:17] hold the core X. Bits [16:11] hold the core Y (the low end of the row span for a spike). Bits [10:5] hold the spike span high row. Flit bit 41 marks the head and bit 40 marks the tail. Port indices are 0 local, 1 north (+Y), 2 south (-Y), 3 east (+X), 4 west (-X).
- R2: A head whose chip number differs from `chip_id_i` goes out the west port only.
- R3: An on-chip head whose X differs from `my_x_i` goes east if the X is greater and west if it is smaller, whatever its Y.
- R4: A non-spike head in the node's own column goes north, south or local according to its Y compared with `my_y_i`.
- R5: In its column, a spike below its span goes north and a spike above its span goes south. Inside the span it goes to local, plus north if below the high row, plus south if above the low row. The arrival port is never among its outputs.
- R6: A flit moves only when valid and ready are both high. A presented output flit stays valid and unchanged until ready.
- R7: Once an output has carried a non-tail flit, it carries only flits of that packet until the packet's tail.
- R8: Inputs that compete for one output without pause are served in alternation.
- R9: `idle_o` is high exactly when no spike packet is held in the node. It drops the cycle after a spike head is accepted.
- R10: After reset, every output is not valid, every input is ready and `idle_o` is high.
- R11: Every copy of a forked flit carries identical data, and each requested output emits it exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| my_x_i | input | 6 | X coordinate of this node |
| my_y_i | input | 6 | Y coordinate of this node |
| chip_id_i | input | 14 | Number of the chip holding this node |
| in_valid_i | input | 5 | Input flit valid, one bit per port |
| in_flit_i | input | 210 | Input flits, 42 bits per port, port p at [p*42 +: 42] |
| in_ready_o | output | 5 | Input buffer can accept, one bit per port |
| out_valid_o | output | 5 | Output flit valid, one bit per port |
| out_flit_o | output | 210 | Output flits, 42 bits per port |
| out_ready_i | input | 5 | Downstream can accept, one bit per port |
| idle_o | output | 1 | No spike packet held in the node |

## Verification
The bench targets the spike span edges. A node on the high row must not send north, and a spike entering from the south must not turn back south. A router that gets either wrong emits an extra copy or loops a packet. It also starves two multi-flit packets aimed at one output against each other, because a router that re-arbitrates mid-packet interleaves their flits at the local port. It holds an output stalled with a spike inside and expects `idle_o` low and the flit steady. A counter that decrements on the head would raise idle early, and an unlocked output would swap sources under backpressure. Alternation between two busy inputs catches a rotation pointer that never advances.

// File: rtl/spike_router_pkg.sv
package spike_router_pkg;
  localparam int NPORT   = 5;
  localparam int DATA_W  = 40;
  localparam int FLIT_W  = DATA_W + 2;
  localparam int HEAD_B  = FLIT_W - 1;
  localparam int TAIL_B  = FLIT_W - 2;
  localparam int COORD_W = 6;
  localparam int CHIP_W  = 14;

  localparam int P_L = 0;
  localparam int P_N = 1;
  localparam int P_S = 2;
  localparam int P_E = 3;
  localparam int P_W = 4;

  typedef enum logic [2:0] {
    MSG_WR    = 3'd0,
    MSG_RDREQ = 3'd1,
    MSG_RDRSP = 3'd2,
    MSG_SPIKE = 3'd3,
    MSG_BAR   = 3'd4
  } msg_e;

  typedef struct packed {
    logic [2:0]         kind;
    logic [CHIP_W-1:0]  chip;
    logic [COORD_W-1:0] x;
    logic [COORD_W-1:0] y;
    logic [COORD_W-1:0] y_hi;
    logic [4:0]         spare;
  } hdr_t;
endpackage

// File: rtl/rt_fifo.sv
module rt_fifo #(
  parameter int W     = 42,
  parameter int DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  output logic         full_o,
  input  logic         pop_i,
  output logic [W-1:0] data_o,
  output logic         empty_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign data_o  = mem[rd_q];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_i) mem[wr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= nxt(wr_q);
      if (pop_i)  rd_q <= nxt(rd_q);
      cnt_q <= cnt_q + CW'(push_i) - CW'(pop_i);
    end
  end

  // R6
  fifo_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  // R6
  fifo_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/rt_route.sv
module rt_route
  import spike_router_pkg::*;
(
  input  logic [DATA_W-1:0]  data_i,
  input  logic [2:0]         in_port_i,
  input  logic [COORD_W-1:0] my_x_i,
  input  logic [COORD_W-1:0] my_y_i,
  input  logic [CHIP_W-1:0]  chip_id_i,
  output logic [NPORT-1:0]   mask_o
);
  hdr_t               h;
  logic [COORD_W-1:0] hi;
  logic [NPORT-1:0]   m, back;

  assign h = hdr_t'(data_i);

  always_comb begin
    hi = (h.kind == MSG_SPIKE && h.y_hi > h.y) ? h.y_hi : h.y;
    m  = '0;
    if (h.chip != chip_id_i)   m[P_W] = 1'b1;
    else if (h.x > my_x_i)     m[P_E] = 1'b1;
    else if (h.x < my_x_i)     m[P_W] = 1'b1;
    else if (my_y_i < h.y)     m[P_N] = 1'b1;
    else if (my_y_i > hi)      m[P_S] = 1'b1;
    else begin
      m[P_L] = 1'b1;
      if (my_y_i < hi)  m[P_N] = 1'b1;
      if (my_y_i > h.y) m[P_S] = 1'b1;
    end
    back = '0;
    if (in_port_i != 3'(P_L)) back[in_port_i] = 1'b1;
    mask_o = m & ~back;
  end
endmodule

// File: rtl/rt_rr_arb.sv
module rt_rr_arb #(
  parameter int N = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  input  logic         adv_i,
  output logic [N-1:0] gnt_o
);
  localparam int PW = $clog2(N);

  logic [PW-1:0] ptr_q, win;

  always_comb begin
    gnt_o = '0;
    win   = '0;
    for (int k = N - 1; k >= 0; k--) begin
      int idx;
      idx = int'(ptr_q) + k;
      if (idx >= N) idx = idx - N;
      if (req_i[idx]) begin
        gnt_o = '0;
        gnt_o[idx] = 1'b1;
        win = PW'(idx);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else if (adv_i && |req_i) ptr_q <= (win == PW'(N - 1)) ? '0 : win + 1'b1;
  end

  // R8
  gnt_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));
  // R8
  gnt_in_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o & ~req_i) == '0);
endmodule

// File: rtl/spike_router.sv
module spike_router
  import spike_router_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [COORD_W-1:0]      my_x_i,
  input  logic [COORD_W-1:0]      my_y_i,
  input  logic [CHIP_W-1:0]       chip_id_i,
  input  logic [NPORT-1:0]        in_valid_i,
  input  logic [NPORT*FLIT_W-1:0] in_flit_i,
  output logic [NPORT-1:0]        in_ready_o,
  output logic [NPORT-1:0]        out_valid_o,
  output logic [NPORT*FLIT_W-1:0] out_flit_o,
  input  logic [NPORT-1:0]        out_ready_i,
  output logic                    idle_o
);
  localparam int CNT_W = $clog2(NPORT * DEPTH + 1);

  logic [FLIT_W-1:0] q_flit   [NPORT];
  logic [NPORT-1:0]  q_empty, q_full, q_push, q_pop;
  logic [NPORT-1:0]  rmask    [NPORT];
  logic [NPORT-1:0]  cur_mask [NPORT];
  logic [NPORT-1:0]  held_mask_q [NPORT];
  logic [NPORT-1:0]  sent_q   [NPORT];
  logic [NPORT-1:0]  cur_spk, held_spk_q, push_spk, pop_spk;

  logic [NPORT-1:0]  req   [NPORT];   // req[o][i]
  logic [NPORT-1:0]  gnt   [NPORT];
  logic [2:0]        src   [NPORT];
  logic [2:0]        owner_q [NPORT];
  logic [NPORT-1:0]  locked_q, fire, arb_adv;

  logic [CNT_W-1:0]  spk_cnt_q, inc_n, dec_n;

  // input side
  for (genvar i = 0; i < NPORT; i++) begin : g_in
    logic [FLIT_W-1:0] in_f;
    hdr_t              in_h;
    assign in_f = in_flit_i[i*FLIT_W +: FLIT_W];
    assign in_h = hdr_t'(in_f[DATA_W-1:0]);
    assign in_ready_o[i] = !q_full[i];
    assign q_push[i]     = in_valid_i[i] && !q_full[i];
    assign push_spk[i]   = q_push[i] && in_f[HEAD_B] && in_h.kind == MSG_SPIKE;

    rt_fifo #(.W(FLIT_W), .DEPTH(DEPTH)) u_fifo (
      .clk_i, .rst_ni,
      .push_i(q_push[i]), .data_i(in_f), .full_o(q_full[i]),
      .pop_i(q_pop[i]), .data_o(q_flit[i]), .empty_o(q_empty[i])
    );

    rt_route u_route (
      .data_i(q_flit[i][DATA_W-1:0]), .in_port_i(3'(i)),
      .my_x_i, .my_y_i, .chip_id_i, .mask_o(rmask[i])
    );

    hdr_t q_h;
    assign q_h         = hdr_t'(q_flit[i][DATA_W-1:0]);
    assign cur_mask[i] = q_flit[i][HEAD_B] ? rmask[i] : held_mask_q[i];
    assign cur_spk[i]  = q_flit[i][HEAD_B] ? (q_h.kind == MSG_SPIKE) : held_spk_q[i];
    assign pop_spk[i]  = q_pop[i] && q_flit[i][TAIL_B] && cur_spk[i];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        held_mask_q[i] <= '0;
        held_spk_q[i]  <= 1'b0;
      end else if (q_pop[i] && q_flit[i][HEAD_B]) begin
        held_mask_q[i] <= rmask[i];
        held_spk_q[i]  <= q_h.kind == MSG_SPIKE;
      end
    end
  end

  // requests, pop and per-copy bookkeeping
  always_comb begin
    for (int o = 0; o < NPORT; o++)
      for (int i = 0; i < NPORT; i++)
        req[o][i] = !q_empty[i] && cur_mask[i][o] && !sent_q[i][o];
    for (int i = 0; i < NPORT; i++) begin
      logic all_done;
      all_done = 1'b1;
      for (int o = 0; o < NPORT; o++)
        if (cur_mask[i][o] && !sent_q[i][o] && !(fire[o] && src[o] == 3'(i)))
          all_done = 1'b0;
      q_pop[i] = !q_empty[i] && all_done;
    end
  end

  for (genvar i = 0; i < NPORT; i++) begin : g_sent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sent_q[i] <= '0;
      else if (q_pop[i]) sent_q[i] <= '0;
      else
        for (int o = 0; o < NPORT; o++)
          if (fire[o] && src[o] == 3'(i)) sent_q[i][o] <= 1'b1;
    end
  end

  // output side
  for (genvar o = 0; o < NPORT; o++) begin : g_out
    rt_rr_arb #(.N(NPORT)) u_arb (
      .clk_i, .rst_ni, .req_i(req[o]), .adv_i(arb_adv[o]), .gnt_o(gnt[o])
    );

    always_comb begin
      src[o] = owner_q[o];
      if (!locked_q[o])
        for (int i = 0; i < NPORT; i++)
          if (gnt[o][i]) src[o] = 3'(i);
    end

    assign out_valid_o[o] = locked_q[o] ? req[o][owner_q[o]] : |req[o];
    assign arb_adv[o]     = out_valid_o[o] && !locked_q[o];
    assign fire[o]        = out_valid_o[o] && out_ready_i[o];
    assign out_flit_o[o*FLIT_W +: FLIT_W] = q_flit[src[o]];

    // hold the output from first presentation until the tail leaves
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        locked_q[o] <= 1'b0;
        owner_q[o]  <= '0;
      end else if (out_valid_o[o]) begin
        locked_q[o] <= !(out_ready_i[o] && q_flit[src[o]][TAIL_B]);
        owner_q[o]  <= src[o];
      end
    end

    // R6
    out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      out_valid_o[o] && !out_ready_i[o] |=>
        out_valid_o[o] && $stable(out_flit_o[o*FLIT_W +: FLIT_W]));
    // R7
    pkt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fire[o] && !out_flit_o[o*FLIT_W + TAIL_B] |=> src[o] == $past(src[o]));
  end

  // spike occupancy
  always_comb begin
    inc_n = '0;
    dec_n = '0;
    for (int i = 0; i < NPORT; i++) begin
      inc_n = inc_n + CNT_W'(push_spk[i]);
      dec_n = dec_n + CNT_W'(pop_spk[i]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) spk_cnt_q <= '0;
    else         spk_cnt_q <= spk_cnt_q + inc_n - dec_n;
  end

  assign idle_o = (spk_cnt_q == '0);

  // R9
  idle_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_n != '0 |=> !idle_o);
  // R10
  reset_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> out_valid_o == '0);
endmodule

// File: tb/spike_router_tb.sv
module spike_router_tb;
  import spike_router_pkg::*;

  localparam int CLK_P = 10;
  localparam int NV    = 12;
  localparam int VW    = 43;

  logic                    clk = 0, rst_n = 0;
  logic [NPORT-1:0]        in_valid = '0, in_ready, out_valid, out_ready = '1;
  logic [NPORT*FLIT_W-1:0] in_flit = '0, out_flit;
  logic                    idle;

  int checks = 0, failures = 0;
  bit done = 0;

  int                fire_cnt [NPORT];
  logic [FLIT_W-1:0] last_f   [NPORT];
  logic [4:0]        seq [16];
  int                seq_n = 0;

  always #(CLK_P/2) clk = ~clk;

  spike_router u_dut (
    .clk_i(clk), .rst_ni(rst_n), .my_x_i(6'd3), .my_y_i(6'd3), .chip_id_i(14'd5),
    .in_valid_i(in_valid), .in_flit_i(in_flit), .in_ready_o(in_ready),
    .out_valid_o(out_valid), .out_flit_o(out_flit), .out_ready_i(out_ready),
    .idle_o(idle)
  );

  always @(posedge clk) begin
    if (rst_n)
      for (int o = 0; o < NPORT; o++)
        if (out_valid[o] && out_ready[o]) begin
          fire_cnt[o] = fire_cnt[o] + 1;
          last_f[o]   = out_flit[o*FLIT_W +: FLIT_W];
          if (o == P_L && seq_n < 16) begin
            seq[seq_n] = out_flit[4:0];
            seq_n = seq_n + 1;
          end
        end
  end

  // port, kind, chip, x, y, y_hi, expected mask {W,E,S,N,L}
  localparam logic [VW-1:0] VEC [NV] = '{
    {3'd0, 3'd0, 14'd5, 6'd3, 6'd3, 6'd0, 5'b00001},  // R4 local
    {3'd0, 3'd1, 14'd5, 6'd5, 6'd1, 6'd0, 5'b01000},  // R3 east
    {3'd1, 3'd2, 14'd5, 6'd1, 6'd6, 6'd0, 5'b10000},  // R3 west
    {3'd4, 3'd4, 14'd5, 6'd3, 6'd6, 6'd0, 5'b00010},  // R4 north
    {3'd3, 3'd0, 14'd5, 6'd3, 6'd0, 6'd0, 5'b00100},  // R4 south
    {3'd0, 3'd0, 14'd9, 6'd3, 6'd3, 6'd0, 5'b10000},  // R2 off chip
    {3'd4, 3'd3, 14'd5, 6'd3, 6'd1, 6'd5, 5'b00111},  // R5 mid span
    {3'd2, 3'd3, 14'd5, 6'd3, 6'd1, 6'd5, 5'b00011},  // R5 no U-turn
    {3'd1, 3'd3, 14'd5, 6'd3, 6'd3, 6'd3, 5'b00001},  // R5 single row
    {3'd3, 3'd3, 14'd5, 6'd3, 6'd5, 6'd6, 5'b00010},  // R5 below span
    {3'd4, 3'd3, 14'd5, 6'd6, 6'd0, 6'd6, 5'b01000},  // R3 spike x first
    {3'd1, 3'd3, 14'd5, 6'd3, 6'd0, 6'd3, 5'b00101}   // R5 high row edge
  };

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [FLIT_W-1:0] mk(input bit h, input bit t, input logic [2:0] k,
      input logic [13:0] c, input logic [5:0] x, input logic [5:0] y, input logic [5:0] yh,
      input logic [4:0] tag);
    return {h, t, k, c, x, y, yh, tag};
  endfunction

  task automatic send(input int p, input logic [FLIT_W-1:0] f);
    @(negedge clk);
    in_valid[p] = 1'b1;
    in_flit[p*FLIT_W +: FLIT_W] = f;
    forever begin
      bit rdy;
      #1 rdy = in_ready[p];
      @(posedge clk);
      if (rdy) break;
      @(negedge clk);
    end
    @(negedge clk);
    in_valid[p] = 1'b0;
  endtask

  task automatic clear_mon();
    @(negedge clk);
    for (int o = 0; o < NPORT; o++) fire_cnt[o] = 0;
    seq_n = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    for (int o = 0; o < NPORT; o++) fire_cnt[o] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10 reset state
    chk(out_valid == '0, "R10 out_valid", 64'(out_valid), 0);
    chk(in_ready == '1, "R10 in_ready", 64'(in_ready), 64'h1f);
    chk(idle == 1'b1, "R10 idle", 64'(idle), 1);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R1 R2 R3 R4 R5 R11 vector walk
    for (int v = 0; v < NV; v++) begin
      logic [VW-1:0]     e;
      logic [FLIT_W-1:0] f;
      logic [4:0]        obs;
      e = VEC[v];
      f = mk(1, 1, e[39:37], e[36:23], e[22:17], e[16:11], e[10:5], 5'(v));
      clear_mon();
      send(int'(e[42:40]), f);
      repeat (6) @(negedge clk);
      obs = '0;
      for (int o = 0; o < NPORT; o++) obs[o] = fire_cnt[o] > 0;
      chk(obs == e[4:0], $sformatf("R1 route vec %0d", v), 64'(obs), 64'(e[4:0]));
      for (int o = 0; o < NPORT; o++)
        if (e[o]) chk(fire_cnt[o] == 1 && last_f[o] == f,
                      $sformatf("R11 copy vec %0d port %0d", v, o), 64'(last_f[o]), 64'(f));
      chk(idle == 1'b1, "R9 idle after drain", 64'(idle), 1);
    end

    // R6 R9 stall with a spike inside
    clear_mon();
    out_ready[P_L] = 1'b0;
    send(P_W, mk(1, 1, MSG_SPIKE, 14'd5, 6'd3, 6'd3, 6'd3, 5'd7));
    repeat (3) @(negedge clk);
    chk(idle == 1'b0, "R9 idle low while held", 64'(idle), 0);
    chk(out_valid[P_L] == 1'b1, "R6 valid held", 64'(out_valid[P_L]), 1);
    chk(fire_cnt[P_L] == 0, "R6 no transfer without ready", 64'(fire_cnt[P_L]), 0);
    out_ready[P_L] = 1'b1;
    repeat (3) @(negedge clk);
    chk(fire_cnt[P_L] == 1, "R6 transfer on ready", 64'(fire_cnt[P_L]), 1);
    chk(idle == 1'b1, "R9 idle after spike leaves", 64'(idle), 1);

    // R7 two 3-flit packets contend for local
    clear_mon();
    fork
      begin
        send(P_N, mk(1, 0, MSG_WR, 14'd5, 6'd3, 6'd3, 6'd0, 5'd10));
        send(P_N, {2'b00, 35'd0, 5'd10});
        send(P_N, {2'b01, 35'd0, 5'd10});
      end
      begin
        send(P_E, mk(1, 0, MSG_WR, 14'd5, 6'd3, 6'd3, 6'd0, 5'd20));
        send(P_E, {2'b00, 35'd0, 5'd20});
        send(P_E, {2'b01, 35'd0, 5'd20});
      end
    join
    repeat (8) @(negedge clk);
    chk(seq_n == 6, "R7 flit count", 64'(seq_n), 6);
    chk(seq[0] == seq[1] && seq[1] == seq[2] && seq[3] == seq[4] && seq[4] == seq[5]
        && seq[0] != seq[3], "R7 no interleave",
        64'({seq[0], seq[1], seq[2], seq[3], seq[4], seq[5]}), 64'(0));

    // R8 alternation between two busy inputs
    clear_mon();
    out_ready[P_L] = 1'b0;
    fork
      begin
        send(P_N, mk(1, 1, MSG_WR, 14'd5, 6'd3, 6'd3, 6'd0, 5'd1));
        send(P_N, mk(1, 1, MSG_WR, 14'd5, 6'd3, 6'd3, 6'd0, 5'd2));
      end
      begin
        send(P_S, mk(1, 1, MSG_WR, 14'd5, 6'd3, 6'd3, 6'd0, 5'd17));
        send(P_S, mk(1, 1, MSG_WR, 14'd5, 6'd3, 6'd3, 6'd0, 5'd18));
      end
    join
    @(negedge clk);
    out_ready[P_L] = 1'b1;
    repeat (8) @(negedge clk);
    chk(seq_n == 4, "R8 count", 64'(seq_n), 4);
    for (int k = 0; k < 3; k++)
      chk(seq[k][4] != seq[k+1][4], $sformatf("R8 alternate at %0d", k),
          64'(seq[k+1]), 64'(seq[k]));
    chk(idle == 1'b1, "R9 idle at end", 64'(idle), 1);

    finish_run();
  end
endmodule